// File: doc/BRIEF.md
# Segment Translation Privilege Checker

This block turns a logical address into a 32-bit linear address and applies segment protection on the way. A logical address is a 16-bit selector paired with a 32-bit offset. Bits 15:3 of the selector pick an entry in a small on-block descriptor table. The chosen entry supplies a 32-bit base, a 20-bit byte-granular limit and a 2-bit privilege level. The linear address is the base plus the offset.

On every request the block compares the current privilege level against the entry's privilege level. The current level is bits 1:0 of the code selector input, and level 0 is the most privileged. It also checks the offset against the limit. One clock later it answers with either the linear address or a fault and a cause code. Software-side logic fills the table through a simple write port, one 64-bit entry per cycle.

Top module: `seg_xlate_top`

## Requirements
- R1: `rsp_valid` is high in the cycle after each cycle with `req_valid` high, and low otherwise; when it is low, the other response outputs are zero.
- R2: A request without a fault returns `rsp_lin_addr` = base + offset, modulo 2^32.
- R3: The table index is `req_sel[15:3]`; `req_sel[2:0]` has no effect on the response.
- R4: An index of 0, or an index not below the table depth (16 by default), faults with cause 1.
- R5: The current level is `code_sel[1:0]`. Access is allowed when that level is numerically less than or equal to the entry level. Otherwise the request faults with cause 2, so level 0 reaches any entry and level 3 reaches only level-3 entries.
- R6: An offset greater than the zero-extended 20-bit limit faults with cause 3; an offset equal to the limit is allowed.
- R7: When several faults apply, cause 1 wins over cause 2, and cause 2 wins over cause 3.
- R8: A table write stores `tbl_wr_data` at `tbl_wr_idx` with base in bits 31:0, limit in bits 51:32, a type field in bits 55:52 and the entry level in bits 57:56. A request in the same cycle sees the old entry, and a request in any later cycle sees the new one.
- R9: Reset (`rst_n` low) clears every entry to all zeros and drives all response outputs to zero.
- R10: On a fault `rsp_fault` is 1 and `rsp_lin_addr` is 0. Without a fault, `rsp_fault` and `rsp_cause` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tbl_wr_en | input | 1 | Table write strobe |
| tbl_wr_idx | input | IDX_W (4) | Entry written |
| tbl_wr_data | input | 64 | Entry contents |
| code_sel | input | 16 | Code selector; bits 1:0 give the current level |
| req_valid | input | 1 | Access request strobe |
| req_sel | input | 16 | Segment selector of the access |
| req_offset | input | 32 | Offset inside the segment |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_lin_addr | output | 32 | Linear address, zero on a fault |
| rsp_fault | output | 1 | Access refused |
| rsp_cause | output | 2 | 0 none, 1 selector, 2 privilege, 3 limit |

## Verification
The bench targets several corner cases.

- **Limit boundary.** It uses an offset exactly at the limit and one byte past it. A design with `>=` in place of `>` would refuse the in-limit access.
- **Base-plus-offset wrap.** A carry out of bit 31 must be dropped. A design that saturated would return a wrong linear address.
- **Privilege levels.** It uses levels 1 and 2, as well as 0 and 3. A design that only tested for level 3 would let level 2 into a level-1 segment.
- **Fault priority.** Requests that break several rules at once expose a wrong fault order through the cause code.
- **Write port.** A write and a read of the same entry in one cycle, and table indices past the depth, catch forwarding and aliasing mistakes.

// File: rtl/seg_xlate_pkg.sv
// Package: shared types for the segment translation block.
// Assumes a 64-bit entry with the packed layout below (MSB first).
package seg_xlate_pkg;

    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'd0,
        CAUSE_SEL   = 2'd1,
        CAUSE_PRIV  = 2'd2,
        CAUSE_LIMIT = 2'd3
    } fault_cause_e;

    typedef struct packed {
        logic [5:0]  rsvd;   // 63:58
        logic [1:0]  lvl;    // 57:56 entry privilege level
        logic [3:0]  kind;   // 55:52 segment type, stored only
        logic [19:0] limit;  // 51:32 byte limit
        logic [31:0] base;   // 31:0  segment base
    } seg_entry_t;

endpackage

// File: rtl/seg_desc_table.sv
// Module: register-based descriptor store.
// Writes land at the clock edge; the read is combinational, so a read
// in the same cycle as a write returns the previous contents.
// Assumes synchronous active-low reset that zeroes all entries.
module seg_desc_table
    import seg_xlate_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  seg_entry_t       wr_entry,
    input  logic [IDX_W-1:0] rd_idx,
    output seg_entry_t       rd_entry
);

    seg_entry_t store [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        // Purpose: hold one entry, cleared by reset, replaced by a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                store[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                store[g] <= wr_entry;
            end
        end
    end

    // Purpose: present the addressed entry.
    always_comb begin
        rd_entry = store[rd_idx];
    end

endmodule

// File: rtl/seg_sel_decode.sv
// Module: selector decode.
// Extracts the table index from selector bits 15:3 and flags a
// null index (0) or one beyond the table depth as unusable.
module seg_sel_decode #(
    parameter int SEL_W   = 16,
    parameter int ENTRIES = 16,
    parameter int IDX_W   = $clog2(ENTRIES),
    localparam int FLD_W  = SEL_W - 3
) (
    input  logic [SEL_W-1:0] sel,
    output logic [IDX_W-1:0] idx,
    output logic             sel_ok
);

    logic [FLD_W-1:0] fld;

    // Purpose: slice the index field and judge it.
    always_comb begin
        fld    = sel[SEL_W-1:3];
        idx    = fld[IDX_W-1:0];
        sel_ok = (fld != '0) && (fld < FLD_W'(ENTRIES));
    end

endmodule

// File: rtl/seg_access_check.sv
// Module: privilege and limit check plus base addition.
// Purely combinational. The fault order is selector, then privilege,
// then limit. The address output is forced to zero on any fault.
module seg_access_check
    import seg_xlate_pkg::*;
#(
    parameter int OFF_W = 32,
    parameter int LIM_W = 20
) (
    input  logic             sel_ok,
    input  logic [1:0]       cur_lvl,
    input  logic [1:0]       seg_lvl,
    input  logic [LIM_W-1:0] limit,
    input  logic [OFF_W-1:0] base,
    input  logic [OFF_W-1:0] offset,
    output logic             fault,
    output fault_cause_e     cause,
    output logic [OFF_W-1:0] lin_addr
);

    logic priv_ok;
    logic lim_ok;

    // Purpose: evaluate each rule and rank the outcome.
    always_comb begin
        priv_ok = (cur_lvl <= seg_lvl);
        lim_ok  = (offset <= {{(OFF_W-LIM_W){1'b0}}, limit});
        if (!sel_ok) begin
            cause = CAUSE_SEL;
        end else if (!priv_ok) begin
            cause = CAUSE_PRIV;
        end else if (!lim_ok) begin
            cause = CAUSE_LIMIT;
        end else begin
            cause = CAUSE_NONE;
        end
        fault    = (cause != CAUSE_NONE);
        lin_addr = fault ? '0 : (base + offset);
    end

endmodule

// File: rtl/seg_xlate_top.sv
// Module: segment translation with privilege checking.
// Looks up the selected descriptor, checks it and registers the result
// one cycle after the request. Synchronous active-low reset.
module seg_xlate_top
    import seg_xlate_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int IDX_W   = $clog2(ENTRIES),
    parameter int SEL_W   = 16,
    parameter int OFF_W   = 32,
    parameter int LIM_W   = 20,
    localparam int ENT_W  = $bits(seg_entry_t)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tbl_wr_en,
    input  logic [IDX_W-1:0] tbl_wr_idx,
    input  logic [ENT_W-1:0] tbl_wr_data,
    input  logic [SEL_W-1:0] code_sel,
    input  logic             req_valid,
    input  logic [SEL_W-1:0] req_sel,
    input  logic [OFF_W-1:0] req_offset,
    output logic             rsp_valid,
    output logic [OFF_W-1:0] rsp_lin_addr,
    output logic             rsp_fault,
    output logic [1:0]       rsp_cause
);

    logic [IDX_W-1:0] rd_idx;
    logic             sel_ok;
    seg_entry_t       rd_entry;
    logic             chk_fault;
    fault_cause_e     chk_cause;
    logic [OFF_W-1:0] chk_addr;

    seg_desc_table #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tbl_wr_en),
        .wr_idx   (tbl_wr_idx),
        .wr_entry (seg_entry_t'(tbl_wr_data)),
        .rd_idx   (rd_idx),
        .rd_entry (rd_entry)
    );

    seg_sel_decode #(.SEL_W(SEL_W), .ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_dec (
        .sel    (req_sel),
        .idx    (rd_idx),
        .sel_ok (sel_ok)
    );

    seg_access_check #(.OFF_W(OFF_W), .LIM_W(LIM_W)) u_chk (
        .sel_ok   (sel_ok),
        .cur_lvl  (code_sel[1:0]),
        .seg_lvl  (rd_entry.lvl),
        .limit    (rd_entry.limit),
        .base     (rd_entry.base),
        .offset   (req_offset),
        .fault    (chk_fault),
        .cause    (chk_cause),
        .lin_addr (chk_addr)
    );

    // Purpose: register the response; idle cycles give an all-zero response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_fault    <= 1'b0;
            rsp_cause    <= 2'd0;
            rsp_lin_addr <= '0;
        end else begin
            rsp_valid    <= req_valid;
            rsp_fault    <= req_valid & chk_fault;
            rsp_cause    <= req_valid ? 2'(chk_cause) : 2'd0;
            rsp_lin_addr <= req_valid ? chk_addr : '0;
        end
    end

endmodule

// File: rtl/seg_xlate_chk.sv
// Module: protocol checker for seg_xlate_top, attached by bind below.
// Observes ports only.
module seg_xlate_chk #(
    parameter int ENTRIES = 16,
    parameter int SEL_W   = 16,
    parameter int OFF_W   = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [SEL_W-1:0] req_sel,
    input logic [SEL_W-1:0] code_sel,
    input logic             rsp_valid,
    input logic [OFF_W-1:0] rsp_lin_addr,
    input logic             rsp_fault,
    input logic [1:0]       rsp_cause
);

    p_rsp_follows_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_rsp_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_fault && rsp_cause == 2'd0 && rsp_lin_addr == '0));

    p_null_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_sel[SEL_W-1:3] == '0) |=> (rsp_fault && rsp_cause == 2'd1));

    p_top_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && code_sel[1:0] == 2'd0) |=> (rsp_cause != 2'd2));

    p_fault_zero_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_cause != 2'd0 && rsp_lin_addr == '0));

    p_ok_no_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_cause == 2'd0));

endmodule

bind seg_xlate_top seg_xlate_chk #(.ENTRIES(ENTRIES), .SEL_W(SEL_W), .OFF_W(OFF_W)) u_seg_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_sel      (req_sel),
    .code_sel     (code_sel),
    .rsp_valid    (rsp_valid),
    .rsp_lin_addr (rsp_lin_addr),
    .rsp_fault    (rsp_fault),
    .rsp_cause    (rsp_cause)
);

// File: tb/test_seg_xlate_top.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared with the design every cycle.
module test_seg_xlate_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tbl_wr_en = 1'b0;
    logic [3:0]  tbl_wr_idx = '0;
    logic [63:0] tbl_wr_data = '0;
    logic [15:0] code_sel = '0;
    logic        req_valid = 1'b0;
    logic [15:0] req_sel = '0;
    logic [31:0] req_offset = '0;
    logic        rsp_valid;
    logic [31:0] rsp_lin_addr;
    logic        rsp_fault;
    logic [1:0]  rsp_cause;

    int compared = 0;
    int mismatched = 0;

    logic [63:0] m_tab [16];
    logic        pend_we = 1'b0;
    int          pend_idx = 0;
    logic [63:0] pend_data = '0;
    logic        e_valid = 1'b0;
    logic        e_fault = 1'b0;
    logic [1:0]  e_cause = 2'd0;
    logic [31:0] e_addr = '0;
    string       e_tag = "R9";

    always #2.5 clk = ~clk;

    seg_xlate_top i_seg_xlate_top (
        .clk(clk), .rst_n(rst_n), .tbl_wr_en(tbl_wr_en), .tbl_wr_idx(tbl_wr_idx),
        .tbl_wr_data(tbl_wr_data), .code_sel(code_sel), .req_valid(req_valid),
        .req_sel(req_sel), .req_offset(req_offset), .rsp_valid(rsp_valid),
        .rsp_lin_addr(rsp_lin_addr), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause)
    );

    function automatic logic [63:0] mk(input logic [31:0] b, input logic [19:0] l,
                                       input logic [1:0] lv, input logic [3:0] k);
        return {6'd0, lv, k, l, b};
    endfunction

    task automatic compare();
        compared++;
        if (rsp_valid !== e_valid || rsp_fault !== e_fault ||
            rsp_cause !== e_cause || rsp_lin_addr !== e_addr) begin
            mismatched++;
            $display("FAIL %s: actual v=%b f=%b c=%0d a=%h expected v=%b f=%b c=%0d a=%h",
                     e_tag, rsp_valid, rsp_fault, rsp_cause, rsp_lin_addr,
                     e_valid, e_fault, e_cause, e_addr);
        end
    endtask

    // Reference rule set: index/level/limit check, ranked, then base + offset.
    task automatic predict(input logic rv, input logic [15:0] sel,
                           input logic [15:0] cs, input logic [31:0] off);
        int          idx;
        logic [63:0] d;
        e_valid = rv; e_fault = 1'b0; e_cause = 2'd0; e_addr = '0;
        if (!rv) return;
        idx = int'(sel[15:3]);
        if (idx == 0 || idx >= 16) begin
            e_fault = 1'b1; e_cause = 2'd1; return;
        end
        d = m_tab[idx];
        if (int'(cs[1:0]) > int'(d[57:56])) begin
            e_fault = 1'b1; e_cause = 2'd2; return;
        end
        if (off > {12'd0, d[51:32]}) begin
            e_fault = 1'b1; e_cause = 2'd3; return;
        end
        e_addr = d[31:0] + off;
    endtask

    task automatic step(input logic we, input int widx, input logic [63:0] wdata,
                        input logic rv, input logic [15:0] sel, input logic [15:0] cs,
                        input logic [31:0] off, input string tag);
        @(negedge clk);
        compare();
        if (pend_we) m_tab[pend_idx] = pend_data;
        tbl_wr_en = we; tbl_wr_idx = 4'(widx); tbl_wr_data = wdata;
        req_valid = rv; req_sel = sel; code_sel = cs; req_offset = off;
        predict(rv, sel, cs, off);
        e_tag = tag;
        pend_we = we; pend_idx = widx; pend_data = wdata;
    endtask

    task automatic wr(input int i, input logic [63:0] d);
        step(1'b1, i, d, 1'b0, 16'd0, 16'd0, 32'd0, "R8");
    endtask

    task automatic rq(input int i, input logic [2:0] lo, input logic [1:0] cpl,
                      input logic [31:0] off, input string tag);
        step(1'b0, 0, 64'd0, 1'b1, {13'(i), lo}, {14'h0123, cpl}, off, tag);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin : stim
        for (int i = 0; i < 16; i++) m_tab[i] = '0;
        repeat (3) @(negedge clk);
        compare();                       // R9: outputs zero during reset
        rst_n = 1'b1;
        // R9: entries zero after reset: base 0, limit 0, level 0
        rq(5, 3'd0, 2'd0, 32'd0, "R9");
        rq(5, 3'd0, 2'd0, 32'd1, "R9");
        step(1'b0, 0, 64'd0, 1'b0, 16'd0, 16'd0, 32'd0, "R1");
        wr(1, mk(32'h0000_1000, 20'h00FFF, 2'd0, 4'hA));
        wr(2, mk(32'hFFFF_F000, 20'hFFFFF, 2'd3, 4'h2));
        wr(3, mk(32'h4000_0000, 20'h00100, 2'd1, 4'h3));
        wr(15, mk(32'h8000_0000, 20'h00010, 2'd2, 4'h2));
        rq(1, 3'd0, 2'd0, 32'h0000_0ABC, "R2");
        rq(1, 3'd0, 2'd0, 32'h0000_0FFF, "R6");   // at limit, allowed
        rq(1, 3'd0, 2'd0, 32'h0000_1000, "R6");   // one past limit
        rq(2, 3'd0, 2'd3, 32'h0000_2345, "R2");   // wraps past 2^32
        rq(2, 3'd7, 2'd3, 32'h0000_0010, "R3");   // low selector bits ignored
        rq(3, 3'd5, 2'd1, 32'h0000_0050, "R3");
        rq(3, 3'd0, 2'd2, 32'h0000_0050, "R5");   // level 2 into level-1 entry
        rq(1, 3'd0, 2'd3, 32'h0000_0000, "R5");   // user into kernel entry
        rq(15, 3'd0, 2'd2, 32'h0000_0010, "R5");
        rq(15, 3'd0, 2'd3, 32'h0000_0011, "R7");  // privilege over limit
        rq(0, 3'd3, 2'd3, 32'h0000_0000, "R4");
        rq(16, 3'd0, 2'd0, 32'h0000_0000, "R4");  // beyond depth
        rq(8191, 3'd0, 2'd0, 32'h0000_0000, "R4");
        rq(0, 3'd0, 2'd3, 32'hFFFF_FFFF, "R7");   // selector over all
        // R8: write and read of entry 4 in the same cycle sees old contents
        step(1'b1, 4, mk(32'h0010_0000, 20'h00200, 2'd3, 4'h2),
             1'b1, {13'd4, 3'd0}, 16'd3, 32'h0000_0100, "R8");
        rq(4, 3'd0, 2'd3, 32'h0000_0100, "R8");
        step(1'b0, 0, 64'd0, 1'b0, 16'd0, 16'd0, 32'd0, "R1");
        rq(2, 3'd0, 2'd1, 32'h0000_1000, "R1");
        rq(3, 3'd0, 2'd0, 32'h0000_0101, "R6");
        step(1'b0, 0, 64'd0, 1'b0, 16'd0, 16'd0, 32'd0, "R10");
        step(1'b0, 0, 64'd0, 1'b0, 16'd0, 16'd0, 32'd0, "R1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule